// File: doc/BRIEF.md
# Multi-Ported Register File with Live Value Table

This block is a 32-entry, 32-bit register file for a four-slot VLIW datapath. It offers eight asynchronous read ports and four synchronous write ports, and all of them can be used in the same cycle. No storage array has more than one write port and one read port. Each write port owns a set of simple banks, one bank per read port, and writes its data into every bank of its set.

A small table holds one entry per register. Each entry records which write port last wrote that register. Every read port looks up its address in this table and uses the entry to pick, from the banks that belong to it, the copy that holds the newest value.

A static mode input lets the same block serve a two-slot machine (four reads, two writes) or a scalar core (two reads, one write). In those modes the unused ports are switched off: their write enables are ignored and their read data is forced to zero.

Top module: `rf_mp_regfile`

## Requirements
- R1: After reset, every register reads as zero on every enabled read port.
- R2: In the 8R4W mode, four writes to four distinct addresses in one cycle all take effect, and each value can be read on any read port from the next cycle on.
- R3: Reads are combinational. A read of an address that is being written in the same cycle returns the old value, and the new value appears from the following cycle.
- R4: When two or more enabled write ports write the same address in one cycle, the highest-numbered of those ports wins.
- R5: The mode_i encoding is: 2'b00 selects 2R1W (read ports 0-1, write port 0); 2'b01 selects 4R2W (read ports 0-3, write ports 0-1); 2'b10 and 2'b11 both select 8R4W (all ports).
- R6: A read port that the current mode disables drives zero on its data output.
- R7: A write enable on a write port that the current mode disables has no effect on any register.
- R8: Any read port can read any register. Read ports given the same address return the same value.
- R9: Register 0 is an ordinary register and can be written. A register keeps its value until a later write to that same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Port configuration select |
| we_i | input | 4 | Write enable, one bit per write port |
| waddr_i | input | 4x5 | Write address per write port |
| wdata_i | input | 4x32 | Write data per write port |
| raddr_i | input | 8x5 | Read address per read port |
| rdata_o | output | 8x32 | Read data per read port |

## Verification
Several functions can coincide in one cycle. Several write ports can target the same register, and a read can hit a register that is being written in that same cycle. The bench provokes both on purpose: it uses directed cycles in which all four ports write one address, or in which a port reads the address being written. It also runs random phases that confine addresses to a handful of registers, so that collisions happen often. A behavioural model applies the writes in port order after each clock edge. Every read port is compared against that model before the edge, which judges both the priority of the winning port and the rule that a read returns the old value in the cycle of the write.

// File: rtl/rf_mp_pkg.sv
package rf_mp_pkg;

  typedef enum logic [1:0] {
    RF_MODE_SCALAR = 2'b00,
    RF_MODE_DUAL   = 2'b01,
    RF_MODE_QUAD   = 2'b10,
    RF_MODE_QUAD_X = 2'b11
  } rf_mode_e;

  function automatic int unsigned active_ports(rf_mode_e mode, int unsigned full);
    case (mode)
      RF_MODE_SCALAR: return full / 4;
      RF_MODE_DUAL:   return full / 2;
      default:        return full;
    endcase
  endfunction

endpackage

// File: rtl/rf_port_mask.sv
module rf_port_mask
  import rf_mp_pkg::*;
#(
  parameter int unsigned NUM_RD = 8,
  parameter int unsigned NUM_WR = 4
) (
  input  logic [1:0]        mode_i,
  output logic [NUM_RD-1:0] rd_en_o,
  output logic [NUM_WR-1:0] wr_en_o
);

  rf_mode_e mode;
  int unsigned n_rd, n_wr;

  assign mode = rf_mode_e'(mode_i);
  assign n_rd = active_ports(mode, NUM_RD);
  assign n_wr = active_ports(mode, NUM_WR);

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rd_en_o[r] = (r < n_rd);
  end

  for (genvar w = 0; w < NUM_WR; w++) begin : g_wr
    assign wr_en_o[w] = (w < n_wr);
  end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/rf_lvt.sv
module rf_lvt #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned NUM_RD = 8,
  parameter int unsigned NUM_WR = 4,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned SW    = (NUM_WR > 1) ? $clog2(NUM_WR) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_WR-1:0]            we_i,
  input  logic [NUM_WR-1:0][AW-1:0]    waddr_i,
  input  logic [NUM_RD-1:0][AW-1:0]    raddr_i,
  output logic [NUM_RD-1:0][SW-1:0]    sel_o
);

  logic [SW-1:0] live_q [DEPTH];

  // later ports override earlier ones: highest port wins a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) live_q[i] <= '0;
    end else begin
      for (int w = 0; w < NUM_WR; w++) begin
        if (we_i[w]) live_q[waddr_i[w]] <= SW'(w);
      end
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign sel_o[r] = live_q[raddr_i[r]];
  end

endmodule

// File: rtl/rf_mp_regfile.sv
module rf_mp_regfile #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_RD   = 8,
  parameter int unsigned NUM_WR   = 4,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [1:0]                     mode_i,
  input  logic [NUM_WR-1:0]              we_i,
  input  logic [NUM_WR-1:0][AW-1:0]      waddr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0]  wdata_i,
  input  logic [NUM_RD-1:0][AW-1:0]      raddr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdata_o
);

  localparam int unsigned SW = (NUM_WR > 1) ? $clog2(NUM_WR) : 1;

  logic [NUM_RD-1:0]         rd_en;
  logic [NUM_WR-1:0]         wr_en;
  logic [NUM_WR-1:0]         we_act;
  logic [NUM_RD-1:0][SW-1:0] sel;
  logic [DATA_W-1:0]         bank_rd [NUM_WR][NUM_RD];

  rf_port_mask #(
    .NUM_RD (NUM_RD),
    .NUM_WR (NUM_WR)
  ) u_mask (
    .mode_i  (mode_i),
    .rd_en_o (rd_en),
    .wr_en_o (wr_en)
  );

  assign we_act = we_i & wr_en;

  rf_lvt #(
    .DEPTH  (NUM_REGS),
    .NUM_RD (NUM_RD),
    .NUM_WR (NUM_WR)
  ) u_lvt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_act),
    .waddr_i (waddr_i),
    .raddr_i (raddr_i),
    .sel_o   (sel)
  );

  // one bank set per write port, one copy per read port
  for (genvar w = 0; w < NUM_WR; w++) begin : g_wset
    for (genvar r = 0; r < NUM_RD; r++) begin : g_copy
      rf_bank #(
        .DEPTH  (NUM_REGS),
        .DATA_W (DATA_W)
      ) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we_act[w]),
        .waddr_i (waddr_i[w]),
        .wdata_i (wdata_i[w]),
        .raddr_i (raddr_i[r]),
        .rdata_o (bank_rd[w][r])
      );
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_RD; r++) begin
      rdata_o[r] = rd_en[r] ? bank_rd[sel[r]][r] : '0;
    end
  end

endmodule

// File: rtl/rf_mp_chk.sv
module rf_mp_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_RD   = 8,
  parameter int unsigned NUM_WR   = 4,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [1:0]                     mode_i,
  input logic [NUM_WR-1:0]              we_i,
  input logic [NUM_WR-1:0][AW-1:0]      waddr_i,
  input logic [NUM_WR-1:0][DATA_W-1:0]  wdata_i,
  input logic [NUM_RD-1:0][AW-1:0]      raddr_i,
  input logic [NUM_RD-1:0][DATA_W-1:0]  rdata_o
);

  // R6
  for (genvar r = 0; r < NUM_RD; r++) begin : g_off
    off_port_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_i == 2'b00 && r >= NUM_RD/4) || (mode_i == 2'b01 && r >= NUM_RD/2))
      |-> rdata_o[r] == '0);
  end

  // R8
  same_addr_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_i[0] == raddr_i[1]) |-> rdata_o[0] == rdata_o[1]);

  // R4
  top_port_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && we_i[NUM_WR-1])
    |=> (raddr_i[0] != $past(waddr_i[NUM_WR-1]) || rdata_o[0] == $past(wdata_i[NUM_WR-1])));

  // R9
  hold_without_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i == '0) |=> (!$stable(raddr_i) || !$stable(mode_i) || $stable(rdata_o)));

endmodule

bind rf_mp_regfile rf_mp_chk #(
  .NUM_REGS (NUM_REGS),
  .DATA_W   (DATA_W),
  .NUM_RD   (NUM_RD),
  .NUM_WR   (NUM_WR)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .we_i    (we_i),
  .waddr_i (waddr_i),
  .wdata_i (wdata_i),
  .raddr_i (raddr_i),
  .rdata_o (rdata_o)
);

// File: tb/rf_mp_regfile_tb.sv
module rf_mp_regfile_tb;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       mode;
  logic [3:0]       we;
  logic [3:0][4:0]  waddr;
  logic [3:0][31:0] wdata;
  logic [7:0][4:0]  raddr;
  logic [7:0][31:0] rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] model [32];

  always #10 clk = ~clk;

  rf_mp_regfile u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .mode_i  (mode),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  function automatic int n_rd(logic [1:0] m);
    return (m == 2'b00) ? 2 : (m == 2'b01) ? 4 : 8;
  endfunction

  function automatic int n_wr(logic [1:0] m);
    return (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
  endfunction

  task automatic chk(string req, int port, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s port=%0d act=%h exp=%h", req, port, act, exp);
    end
  endtask

  // inputs already driven at negedge; compare, take the edge, update model
  task automatic cycle(string req);
    #2;
    for (int r = 0; r < 8; r++) begin
      chk(req, r, rdata[r], (r < n_rd(mode)) ? model[raddr[r]] : 32'h0);
    end
    @(posedge clk);
    #1;
    for (int w = 0; w < 4; w++) begin
      if (we[w] && w < n_wr(mode)) model[waddr[w]] = wdata[w];
    end
    @(negedge clk);
  endtask

  task automatic idle();
    we = '0; waddr = '0; wdata = '0;
  endtask

  task automatic read_all(string req, int base);
    idle();
    for (int r = 0; r < 8; r++) raddr[r] = 5'(base + r);
    cycle(req);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    mode = 2'b10; idle(); raddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    for (int b = 0; b < 32; b += 8) read_all("R1", b);

    // R2: four distinct writes in one cycle
    we = 4'b1111;
    for (int w = 0; w < 4; w++) begin
      waddr[w] = 5'(10 + w);
      wdata[w] = 32'hA000_0000 + w;
    end
    cycle("R2");
    read_all("R2", 8);
    for (int r = 0; r < 8; r++) raddr[r] = 5'(10 + (r % 4));
    cycle("R2 R8");

    // R3: read during the write returns the old value, new one after
    idle();
    we[1] = 1'b1; waddr[1] = 5'd11; wdata[1] = 32'h3333_0001;
    raddr = '{default: 5'd11};
    cycle("R3");
    idle();
    cycle("R3");

    // R4: all ports on one address, then a partial collision
    we = 4'b1111; waddr = '{default: 5'd5};
    for (int w = 0; w < 4; w++) wdata[w] = 32'h4400_0000 + w;
    cycle("R4");
    idle(); raddr = '{default: 5'd5};
    cycle("R4");
    we = 4'b0111; waddr = '{default: 5'd6};
    for (int w = 0; w < 4; w++) wdata[w] = 32'h4500_0000 + w;
    cycle("R4");
    idle(); raddr = '{default: 5'd6};
    cycle("R4");

    // R5 R6 R7: scalar mode ignores ports 1..3 writes, zeroes reads 2..7
    mode = 2'b00;
    we = 4'b1111; waddr = '{default: 5'd9};
    for (int w = 0; w < 4; w++) wdata[w] = 32'h7700_0000 + w;
    raddr = '{default: 5'd10};
    cycle("R7 R6");
    mode = 2'b10; idle(); raddr = '{default: 5'd9};
    cycle("R7 R5");

    // R5 R7: dual mode, port 1 wins, ports 2,3 ignored
    mode = 2'b01;
    we = 4'b1111; waddr = '{default: 5'd12};
    for (int w = 0; w < 4; w++) wdata[w] = 32'h5500_0000 + w;
    cycle("R5 R6");
    mode = 2'b11; idle(); raddr = '{default: 5'd12};
    cycle("R5 R7");

    // R9: register 0 writable, unaffected by other writes
    mode = 2'b10; idle();
    we[2] = 1'b1; waddr[2] = 5'd0; wdata[2] = 32'h9999_0000;
    cycle("R9");
    idle(); we[0] = 1'b1; waddr[0] = 5'd1; wdata[0] = 32'h9999_0001;
    cycle("R9");
    idle(); raddr = '{default: 5'd0};
    cycle("R9");

    // R8 R4: random traffic with dense collisions, all modes
    for (int ph = 0; ph < 8; ph++) begin
      mode = 2'($urandom_range(0, 3));
      for (int c = 0; c < 60; c++) begin
        we = 4'($urandom);
        for (int w = 0; w < 4; w++) begin
          waddr[w] = (ph % 2 == 0) ? 5'($urandom_range(0, 3)) : 5'($urandom);
          wdata[w] = $urandom;
        end
        for (int r = 0; r < 8; r++)
          raddr[r] = (ph % 2 == 0) ? 5'($urandom_range(0, 3)) : 5'($urandom);
        cycle("R8 R4");
      end
    end

    done = 1;
    summary();
    $finish;
  end

endmodule